// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM Datapath

A single-port synchronous memory with a common data path for reads and writes. Its default size is small. Setting `ADDR_W` to 16 gives the 64K-word organisation, and each word is two 9-bit lanes. Each lane holds eight data bits and one parity bit, and it is always written as one unit.

Every request input is captured on the rising clock edge: select, address, write data, the global write strobe, the byte-write enable and the per-lane strobes. A captured write is committed to the array on the following edge, with no handshake. A captured read loads an output register on the following edge.

The read data bus is gated by an output-enable pipeline with two stages. After a read, a deselected cycle keeps the bus driven for one more cycle. This lets several such memories share one bus without a turnaround wait state.

Two inputs act on the bus without waiting for a clock: the output enable and a sleep input. The sleep input also makes the block ignore any access presented while it is asserted.

Top module: `pipelined_bw_sram`

## Requirements
- R1: With `gw_n` low in a selected cycle, all 18 bits of the addressed word are written, whatever `bwe_n` and `bw_n` are.
- R2: With `gw_n` high and `bwe_n` low, lane i is written only when `bw_n[i]` is low. Lane 0 is bits 8:0 and lane 1 is bits 17:9. Lanes not selected keep their contents.
- R3: A selected cycle with `gw_n` high and no lane chosen is a read and leaves the array unchanged. No lane is chosen when `bwe_n` is high, or when every `bw_n` bit is high.
- R4: A read captured on edge k drives its data on `dq_out`, with `dq_drive` high, from edge k+1 until edge k+2.
- R5: If the cycle captured right after a read is a deselect (`sel` low), the bus stays driven with the same data for one further cycle and then goes idle.
- R6: A write never drives the bus. A read followed directly by a write gets no extra hold cycle.
- R7: `oe_n` high forces `dq_drive` low and `dq_out` to zero at once, without a clock edge. Releasing it restores the pending output.
- R8: `zz` high forces the bus idle at once. Any access presented while `zz` is high is ignored, and the array contents are kept.
- R9: After reset the bus is idle, and `dq_out` reads zero whenever `dq_drive` is low.
- R10: Reads issued on consecutive cycles return one word per cycle, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| sel | input | 1 | Access request for this cycle |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 2 | Per-lane write strobes, active low |
| din | input | 18 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| zz | input | 1 | Sleep: idles the bus and blocks accesses |
| dq_out | output | 18 | Read data, zero when not driven |
| dq_drive | output | 1 | High while the block drives the data bus |

## Verification
A corrupted capture register shows up as wrong data or a wrong lane mask on the read that follows, two edges after the request. For this reason every word is written and then read back under each lane pattern.

A fault in the enable pipeline shows as `dq_drive` being high or low in the wrong cycle. The bench samples each cycle of the window: the data cycle, the hold cycle and the first idle cycle. It covers deselect, write-after-read, sleep and output-enable cases.

A stuck gate on `oe_n` or `zz` is seen within one time step, because the outputs are sampled straight after the input toggles.

// File: rtl/pipelined_bw_sram.sv
module pipelined_bw_sram #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sel,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bw_n,
  input  logic [LANE_W*LANES-1:0]   din,
  input  logic                      oe_n,
  input  logic                      zz,
  output logic [LANE_W*LANES-1:0]   dq_out,
  output logic                      dq_drive
);
  localparam int DATA_W = LANE_W * LANES;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addr_r;
  logic [DATA_W-1:0] din_r, rd_q;
  logic [LANES-1:0]  lane_r, lane_req;
  logic              cap_rd, cap_wr, out_rd, out_hold, accept;

  assign lane_req = !gw_n ? {LANES{1'b1}} : (!bwe_n ? ~bw_n : {LANES{1'b0}});
  assign accept   = sel & ~zz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_rd   <= 1'b0;
      cap_wr   <= 1'b0;
      out_rd   <= 1'b0;
      out_hold <= 1'b0;
    end else begin
      cap_rd   <= accept & ~(|lane_req);
      cap_wr   <= accept & (|lane_req);
      out_rd   <= cap_rd;
      out_hold <= out_rd & ~cap_rd & ~cap_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_r <= addr;
      din_r  <= din;
      lane_r <= lane_req;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_wr)
      for (int l = 0; l < LANES; l++)
        if (lane_r[l])
          mem[addr_r][l*LANE_W +: LANE_W] <= din_r[l*LANE_W +: LANE_W];
    if (cap_rd)
      rd_q <= mem[addr_r];
  end

  assign dq_drive = (out_rd | out_hold) & ~oe_n & ~zz;
  assign dq_out   = dq_drive ? rd_q : {DATA_W{1'b0}};

  logic req_rd, req_idle;
  assign req_rd   = sel && !zz && gw_n && (bwe_n || (&bw_n));
  assign req_idle = !sel || zz;

  assert_idle_after_reset_R9: assert property (@(posedge clk)
    !rst_n |=> !dq_drive);

  assert_read_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd |=> ##1 (dq_drive || oe_n || zz));

  assert_deselect_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd ##1 req_idle |=> ##1 (dq_drive || oe_n || zz));

  assert_hold_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_rd ##1 req_idle ##1 req_idle |=> ##1 !dq_drive);

  assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !zz && !req_rd) |=> ##1 !dq_drive);
endmodule

// File: tb/test_pipelined_bw_sram.sv
module test_pipelined_bw_sram;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 1'b0, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0, zz = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [1:0]  bw_n = 2'b11;
  logic [17:0] din = '0;
  logic [17:0] dq_out;
  logic        dq_drive;
  logic [17:0] model [DEPTH];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pipelined_bw_sram i_pipelined_bw_sram (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .din(din), .oe_n(oe_n), .zz(zz),
    .dq_out(dq_out), .dq_drive(dq_drive));

  task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [17:0] pat(input int a, input int salt);
    return 18'((a * 2971 + salt) ^ (a << 9));
  endfunction

  task automatic idle();
    sel = 1'b0; gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
  endtask

  task automatic put_read(input int a);
    sel = 1'b1; addr = ADDR_W'(a); gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
  endtask

  task automatic put_write(input int a, input logic g, input logic be, input logic [1:0] bw, input logic [17:0] d);
    logic [1:0] m;
    sel = 1'b1; addr = ADDR_W'(a); gw_n = g; bwe_n = be; bw_n = bw; din = d;
    m = !g ? 2'b11 : (!be ? ~bw : 2'b00);
    if (!zz) begin
      if (m[0]) model[a][8:0]  = d[8:0];
      if (m[1]) model[a][17:9] = d[17:9];
    end
  endtask

  task automatic readback(input int a, input string req);
    put_read(a); @(negedge clk);
    idle(); @(negedge clk);
    chk(dq_drive && dq_out == model[a], {req, " R4 read data"}, dq_out, model[a]);
    @(negedge clk);
    chk(dq_drive && dq_out == model[a], "R5 deselect hold", dq_out, model[a]);
    @(negedge clk);
    chk(!dq_drive && dq_out == 18'd0, "R5 hold ends", {17'd0, dq_drive}, 18'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(!dq_drive && dq_out == 18'd0, "R9 reset idle", dq_out, 18'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int a = 0; a < DEPTH; a++) begin
      put_write(a, 1'b0, a[0], 2'(a), pat(a, 12345));
      @(negedge clk);
    end
    idle(); @(negedge clk);
    chk(!dq_drive, "R6 writes never drive", {17'd0, dq_drive}, 18'd0);
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) readback(a, "R1 full write");

    for (int a = 0; a < DEPTH; a++) begin
      put_write(a, 1'b1, a[2], 2'(a), ~pat(a, 777));
      @(negedge clk);
    end
    idle(); @(negedge clk);
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) readback(a, (a[2] || a[1:0] == 2'b11) ? "R3 no-lane read" : "R2 lane write");

    for (int i = 0; i < 18; i++) begin
      if (i >= 2)
        chk(dq_drive && dq_out == model[i-2], "R10 streamed read", dq_out, model[i-2]);
      if (i < 16) put_read(i); else idle();
      @(negedge clk);
    end
    repeat (3) @(negedge clk);

    put_read(5); @(negedge clk);
    put_write(9, 1'b0, 1'b1, 2'b11, 18'h2A5A5); @(negedge clk);
    idle();
    chk(dq_drive && dq_out == model[5], "R6 read before write", dq_out, model[5]);
    @(negedge clk);
    chk(!dq_drive, "R6 no hold into write", {17'd0, dq_drive}, 18'd0);
    @(negedge clk);
    readback(9, "R6 write landed");

    put_read(12); @(negedge clk);
    idle(); @(negedge clk);
    oe_n = 1'b1; #1;
    chk(!dq_drive && dq_out == 18'd0, "R7 oe_n async off", dq_out, 18'd0);
    oe_n = 1'b0; #1;
    chk(dq_drive && dq_out == model[12], "R7 oe_n release", dq_out, model[12]);
    zz = 1'b1; #1;
    chk(!dq_drive && dq_out == 18'd0, "R8 sleep async off", dq_out, 18'd0);
    @(negedge clk);
    put_write(20, 1'b0, 1'b1, 2'b11, 18'h0F0F0); @(negedge clk);
    put_read(20); @(negedge clk);
    zz = 1'b0; idle(); @(negedge clk);
    chk(!dq_drive, "R8 read in sleep ignored", {17'd0, dq_drive}, 18'd0);
    @(negedge clk);
    readback(20, "R8 array kept");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule